// File: doc/BRIEF.md
# Multiply-Accumulate Execution Unit with Flag Update

This unit executes three integer operations on word-sized operands: a plain product, a product plus an addend, and an addend minus a product. Only the low word of each result is kept. The low word of a product does not depend on signedness, so the unit has no signed/unsigned control. A request arrives with operands, an operation select, a set-flags request, a condition-pass bit, the four register indices it names, and the current flag word. One clock later the unit returns a registered result, a write-enable, a response strobe, an illegal-request indication and the next flag word.

The unit refuses malformed requests instead of executing them. A refused request is one that uses the reserved operation code, asks for flags on a multiply-subtract, or names the reserved register index in any position. A refused request writes nothing and leaves the flags as they were. When the condition-pass bit is low, the request is dropped without error. Flag updates change only negative and zero. Carry and overflow are always copied from the incoming flag word.

Top module: `mac_exec_unit`

## Requirements
- R1: Operation select 2'b00 (multiply) writes the low DATA_W bits of opnd_a × opnd_b.
- R2: Operation select 2'b01 (multiply-add) writes the low DATA_W bits of opnd_a × opnd_b + opnd_c, wrapping on overflow.
- R3: Operation select 2'b10 (multiply-subtract) writes the low DATA_W bits of opnd_c − opnd_a × opnd_b.
- R4: Operands given as two's-complement negative values produce the same result bits as the signed product would, with no signedness input.
- R5: flags_in and flags_out are laid out {N,Z,C,V} in bits 3..0. When an accepted multiply or multiply-add has set_flags high, N becomes the result's top bit and Z is set exactly when the result is zero. C and V are copied from flags_in.
- R6: In every other active cycle, including a cycle with no request, flags_out takes the value flags_in had in the previous cycle.
- R7: A request with cond_pass low raises neither wr_en nor illegal. Its flags behave as in R6, and result keeps its value.
- R8: A multiply-subtract with set_flags high is refused. illegal is raised, wr_en stays low, and the flags follow R6.
- R9: A request that names index RSV_IDX (default 15) as destination or as any of the three sources is refused. illegal is raised and wr_en stays low.
- R10: Operation select 2'b11 is refused, and illegal is raised.
- R11: out_valid pulses exactly one cycle after each cycle with in_valid high. wr_en accompanies it only for a request that is accepted (condition passed and not refused). Back-to-back requests each get their own response.
- R12: A synchronous active-high reset clears result, wr_en, out_valid, illegal and flags_out to zero. Outside reset, result changes only on a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A request is present this cycle |
| cond_pass | input | 1 | Condition for the request is met |
| op_sel | input | 2 | 00 multiply, 01 multiply-add, 10 multiply-subtract, 11 reserved |
| set_flags | input | 1 | Request an N/Z update |
| dst_idx | input | IDX_W | Destination register index |
| src_a_idx | input | IDX_W | Index of first multiplicand |
| src_b_idx | input | IDX_W | Index of second multiplicand |
| src_c_idx | input | IDX_W | Index of addend |
| opnd_a | input | DATA_W | First multiplicand |
| opnd_b | input | DATA_W | Second multiplicand |
| opnd_c | input | DATA_W | Addend / minuend |
| flags_in | input | 4 | Current flags {N,Z,C,V} |
| result | output | DATA_W | Registered result |
| wr_en | output | 1 | Result write-enable |
| out_valid | output | 1 | Response strobe |
| illegal | output | 1 | Request was refused |
| flags_out | output | 4 | Next flags {N,Z,C,V} |

## Verification
The bench builds the unit with DATA_W = 32, IDX_W = 4 and RSV_IDX = 15. It sets MUL_ARCH = 1, so the shift-and-add multiplier carries every product, including the all-ones × all-ones case and products whose set bits fall entirely above bit 31. These widths make 32-bit wrap-around, sign-bit N flags and the index-15 refusal reachable with literal operands. A run of pseudo-random operands across all three modes exercises the partial-product sum against products the bench computes independently.

// File: rtl/mac_pkg.sv
package mac_pkg;

   typedef enum logic [1:0] {
      OP_MUL = 2'b00,
      OP_MLA = 2'b01,
      OP_MLS = 2'b10,
      OP_RSV = 2'b11
   } mac_op_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } nzcv_t;

endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
   parameter int W    = 32,
   parameter int ARCH = 0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] p
);

   generate
      if (ARCH == 0) begin : g_native
         assign p = a * b;
      end else begin : g_shift_add
         logic [W-1:0] acc;
         always_comb begin
            acc = '0;
            for (int i = 0; i < W; i++) begin
               if (b[i]) acc = acc + (a << i);
            end
         end
         assign p = acc;
      end
   endgenerate

endmodule

// File: rtl/mac_addsub.sv
module mac_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] prod,
   input  logic [W-1:0] addend,
   input  logic         use_add,
   input  logic         negate,
   output logic [W-1:0] sum
);

   logic [W-1:0] term;

   always_comb begin
      if (!use_add) begin
         sum  = prod;
         term = '0;
      end else begin
         term = negate ? ~prod : prod;
         sum  = addend + term + {{(W-1){1'b0}}, negate};
      end
   end

endmodule

// File: rtl/mac_guard.sv
module mac_guard #(
   parameter int IDX_W   = 4,
   parameter int RSV_IDX = 15,
   parameter int N_IDX   = 4
) (
   input  logic [1:0]             op,
   input  logic                   want_flags,
   input  logic [N_IDX*IDX_W-1:0] idx_bus,
   output logic                   refuse
);

   import mac_pkg::*;

   localparam logic [IDX_W-1:0] RSV = IDX_W'(RSV_IDX);

   logic [N_IDX-1:0] hit;

   generate
      for (genvar k = 0; k < N_IDX; k++) begin : g_idx
         assign hit[k] = (idx_bus[k*IDX_W +: IDX_W] == RSV);
      end
   endgenerate

   always_comb begin
      refuse = |hit;
      if (mac_op_e'(op) == OP_RSV) refuse = 1'b1;
      if (mac_op_e'(op) == OP_MLS && want_flags) refuse = 1'b1;
   end

endmodule

// File: rtl/mac_flags.sv
module mac_flags #(
   parameter int W = 32
) (
   input  logic [W-1:0] res,
   input  logic [3:0]   cur,
   input  logic         upd,
   output logic [3:0]   nxt
);

   import mac_pkg::*;

   nzcv_t c_in, c_out;

   always_comb begin
      c_in  = nzcv_t'(cur);
      c_out = c_in;
      if (upd) begin
         c_out.n = res[W-1];
         c_out.z = (res == '0);
      end
   end

   assign nxt = c_out;

endmodule

// File: rtl/mac_exec_unit.sv
module mac_exec_unit #(
   parameter int DATA_W   = 32,
   parameter int IDX_W    = 4,
   parameter int RSV_IDX  = 15,
   parameter int MUL_ARCH = 0
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic              cond_pass,
   input  logic [1:0]        op_sel,
   input  logic              set_flags,
   input  logic [IDX_W-1:0]  dst_idx,
   input  logic [IDX_W-1:0]  src_a_idx,
   input  logic [IDX_W-1:0]  src_b_idx,
   input  logic [IDX_W-1:0]  src_c_idx,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [DATA_W-1:0] opnd_c,
   input  logic [3:0]        flags_in,
   output logic [DATA_W-1:0] result,
   output logic              wr_en,
   output logic              out_valid,
   output logic              illegal,
   output logic [3:0]        flags_out
);

   import mac_pkg::*;

   localparam int N_IDX = 4;

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("mac_exec_unit: DATA_W must be at least 2");
      end
      if (IDX_W < 1 || RSV_IDX >= (1 << IDX_W) || RSV_IDX < 0) begin : g_bad_idx
         $error("mac_exec_unit: RSV_IDX must fit in IDX_W bits");
      end
      if (MUL_ARCH < 0 || MUL_ARCH > 1) begin : g_bad_arch
         $error("mac_exec_unit: MUL_ARCH must be 0 or 1");
      end
   endgenerate

   logic [DATA_W-1:0] prod, sum_d;
   logic [3:0]        flags_d;
   logic              refuse, issue, accept;
   logic              use_add, negate;

   assign use_add = (mac_op_e'(op_sel) == OP_MLA) || (mac_op_e'(op_sel) == OP_MLS);
   assign negate  = (mac_op_e'(op_sel) == OP_MLS);

   mac_mult #(.W(DATA_W), .ARCH(MUL_ARCH)) u_mult (
      .a (opnd_a),
      .b (opnd_b),
      .p (prod)
   );

   mac_addsub #(.W(DATA_W)) u_addsub (
      .prod    (prod),
      .addend  (opnd_c),
      .use_add (use_add),
      .negate  (negate),
      .sum     (sum_d)
   );

   mac_guard #(.IDX_W(IDX_W), .RSV_IDX(RSV_IDX), .N_IDX(N_IDX)) u_guard (
      .op         (op_sel),
      .want_flags (set_flags),
      .idx_bus    ({src_c_idx, src_b_idx, src_a_idx, dst_idx}),
      .refuse     (refuse)
   );

   assign issue  = in_valid & cond_pass;
   assign accept = issue & ~refuse;

   mac_flags #(.W(DATA_W)) u_flags (
      .res (sum_d),
      .cur (flags_in),
      .upd (accept & set_flags),
      .nxt (flags_d)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         result    <= '0;
         wr_en     <= 1'b0;
         out_valid <= 1'b0;
         illegal   <= 1'b0;
         flags_out <= '0;
      end else begin
         out_valid <= in_valid;
         wr_en     <= accept;
         illegal   <= issue & refuse;
         flags_out <= flags_d;
         if (accept) result <= sum_d;
      end
   end

endmodule

module mac_exec_unit_chk #(
   parameter int DATA_W  = 32,
   parameter int IDX_W   = 4,
   parameter int RSV_IDX = 15
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic              cond_pass,
   input logic [1:0]        op_sel,
   input logic              set_flags,
   input logic [IDX_W-1:0]  dst_idx,
   input logic [IDX_W-1:0]  src_a_idx,
   input logic [IDX_W-1:0]  src_b_idx,
   input logic [IDX_W-1:0]  src_c_idx,
   input logic [DATA_W-1:0] opnd_a,
   input logic [DATA_W-1:0] opnd_b,
   input logic [DATA_W-1:0] opnd_c,
   input logic [3:0]        flags_in,
   input logic [DATA_W-1:0] result,
   input logic              wr_en,
   input logic              out_valid,
   input logic              illegal,
   input logic [3:0]        flags_out
);

   localparam logic [IDX_W-1:0] RSV = IDX_W'(RSV_IDX);

   logic [DATA_W-1:0] mul_ref;
   logic              rsv_hit;
   assign mul_ref = opnd_a * opnd_b;
   assign rsv_hit = (dst_idx == RSV) || (src_a_idx == RSV) ||
                    (src_b_idx == RSV) || (src_c_idx == RSV);

   assert_wr_has_strobe_R11: assert property (@(posedge clk) disable iff (rst)
      wr_en |-> out_valid && !illegal);

   assert_strobe_follows_req_R11: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (out_valid == $past(in_valid)));

   assert_cond_gate_R7: assert property (@(posedge clk) disable iff (rst)
      out_valid && !$past(cond_pass) |-> !wr_en && !illegal);

   assert_cv_copied_R5: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> flags_out[1:0] == $past(flags_in[1:0]));

   assert_mls_flags_refused_R8: assert property (@(posedge clk) disable iff (rst)
      out_valid && $past(cond_pass && op_sel == 2'b10 && set_flags) |-> illegal && !wr_en);

   assert_rsv_index_refused_R9: assert property (@(posedge clk) disable iff (rst)
      out_valid && $past(cond_pass && rsv_hit) |-> illegal && !wr_en);

   assert_rsv_op_refused_R10: assert property (@(posedge clk) disable iff (rst)
      out_valid && $past(cond_pass && op_sel == 2'b11) |-> illegal);

   assert_nz_from_result_R5: assert property (@(posedge clk) disable iff (rst)
      wr_en && $past(set_flags) |->
         flags_out[2] == (result == '0) && flags_out[3] == result[DATA_W-1]);

   assert_mul_low_word_R1: assert property (@(posedge clk) disable iff (rst)
      wr_en && $past(op_sel == 2'b00) |-> result == $past(mul_ref));

   assert_result_hold_R12: assert property (@(posedge clk) disable iff (rst)
      !wr_en && !$past(rst) |-> $stable(result));

endmodule

bind mac_exec_unit mac_exec_unit_chk #(
   .DATA_W  (DATA_W),
   .IDX_W   (IDX_W),
   .RSV_IDX (RSV_IDX)
) u_chk (.*);

// File: tb/sim_mac_exec_unit.sv
module sim_mac_exec_unit;

   localparam int W  = 32;
   localparam int IW = 4;

   typedef struct {
      logic          ov;
      logic          wr;
      logic          ill;
      logic [W-1:0]  res;
      logic [3:0]    fl;
      string         tag;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          in_valid = 1'b0, cond_pass = 1'b0, set_flags = 1'b0;
   logic [1:0]    op_sel = 2'b00;
   logic [IW-1:0] dst_idx = '0, src_a_idx = '0, src_b_idx = '0, src_c_idx = '0;
   logic [W-1:0]  opnd_a = '0, opnd_b = '0, opnd_c = '0;
   logic [3:0]    flags_in = 4'hF;
   logic [W-1:0]  result;
   logic          wr_en, out_valid, illegal;
   logic [3:0]    flags_out;

   int total = 0;
   int bad   = 0;
   exp_t q[$];
   logic [W-1:0] last_res = '0;
   logic [31:0]  lcg = 32'h1234_5678;

   always #2 clk = ~clk;

   mac_exec_unit #(.DATA_W(W), .IDX_W(IW), .RSV_IDX(15), .MUL_ARCH(1)) u0 (
      .clk(clk), .rst(rst), .in_valid(in_valid), .cond_pass(cond_pass),
      .op_sel(op_sel), .set_flags(set_flags), .dst_idx(dst_idx),
      .src_a_idx(src_a_idx), .src_b_idx(src_b_idx), .src_c_idx(src_c_idx),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c), .flags_in(flags_in),
      .result(result), .wr_en(wr_en), .out_valid(out_valid),
      .illegal(illegal), .flags_out(flags_out)
   );

   task automatic issue(input logic v, input logic cp, input logic [1:0] op,
                        input logic sf, input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [W-1:0] c, input logic [IW-1:0] d,
                        input logic [IW-1:0] sa, input logic [IW-1:0] sb,
                        input logic [IW-1:0] sc, input logic [3:0] fin, input string tag);
      exp_t e;
      logic ill, acc;
      logic [W-1:0] r;
      @(negedge clk);
      in_valid = v; cond_pass = cp; op_sel = op; set_flags = sf;
      opnd_a = a; opnd_b = b; opnd_c = c; flags_in = fin;
      dst_idx = d; src_a_idx = sa; src_b_idx = sb; src_c_idx = sc;
      ill = v && cp && (op == 2'b11 || (op == 2'b10 && sf) ||
                        d == 4'd15 || sa == 4'd15 || sb == 4'd15 || sc == 4'd15);
      acc = v && cp && !ill;
      case (op)
         2'b00:   r = a * b;
         2'b01:   r = a * b + c;
         default: r = c - a * b;
      endcase
      if (acc) last_res = r;
      e.ov  = v;
      e.wr  = acc;
      e.ill = ill;
      e.res = last_res;
      e.fl  = (acc && sf) ? {last_res[W-1], last_res == '0, fin[1:0]} : fin;
      e.tag = tag;
      q.push_back(e);
   endtask

   task automatic op(input logic [1:0] o, input logic sf, input logic [W-1:0] a,
                     input logic [W-1:0] b, input logic [W-1:0] c,
                     input logic [3:0] fin, input string tag);
      issue(1'b1, 1'b1, o, sf, a, b, c, 4'd1, 4'd2, 4'd3, 4'd4, fin, tag);
   endtask

   task automatic idle(input logic [3:0] fin, input string tag);
      issue(1'b0, 1'b1, 2'b00, 1'b0, '0, '0, '0, 4'd0, 4'd0, 4'd0, 4'd0, fin, tag);
   endtask

   // monitor: compare each registered response against the scoreboard
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            total++;
            if (out_valid !== e.ov || wr_en !== e.wr || illegal !== e.ill ||
                result !== e.res || flags_out !== e.fl) begin
               bad++;
               $display("FAIL %s: actual v=%b w=%b i=%b r=%h f=%b expected v=%b w=%b i=%b r=%h f=%b",
                        e.tag, out_valid, wr_en, illegal, result, flags_out,
                        e.ov, e.wr, e.ill, e.res, e.fl);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL R11: watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R12: reset state, with busy inputs held during reset
      in_valid = 1'b1; cond_pass = 1'b1; opnd_a = 32'd9; opnd_b = 32'd9;
      repeat (3) @(posedge clk);
      @(negedge clk);
      total++;
      if (result !== '0 || wr_en !== 1'b0 || out_valid !== 1'b0 ||
          illegal !== 1'b0 || flags_out !== 4'h0) begin
         bad++;
         $display("FAIL R12: reset actual r=%h w=%b v=%b i=%b f=%b expected all zero",
                  result, wr_en, out_valid, illegal, flags_out);
      end
      in_valid = 1'b0;
      rst = 1'b0;

      op(2'b00, 1'b0, 32'd7, 32'd6, 32'd0, 4'b0000, "R1 7*6");
      op(2'b00, 1'b0, 32'h0001_0000, 32'h0001_0000, 32'd5, 4'b0000, "R1 product above bit 31");
      op(2'b00, 1'b0, 32'h1234_5678, 32'h0000_0010, 32'd0, 4'b0000, "R1 shift-like product");
      op(2'b01, 1'b0, 32'd3, 32'd4, 32'd5, 4'b0000, "R2 3*4+5");
      op(2'b01, 1'b0, 32'hFFFF_FFFF, 32'd1, 32'd1, 4'b0000, "R2 wrap to zero");
      op(2'b10, 1'b0, 32'd3, 32'd2, 32'd10, 4'b0000, "R3 10-3*2");
      op(2'b10, 1'b0, 32'd1, 32'd2, 32'd1, 4'b0000, "R3 1-2 borrow");
      op(2'b00, 1'b0, 32'hFFFF_FFFD, 32'd5, 32'd0, 4'b0000, "R4 -3*5");
      op(2'b00, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd0, 4'b0000, "R4 -1*-1");
      op(2'b01, 1'b0, 32'hFFFF_FFFE, 32'hFFFF_FFFC, 32'hFFFF_FFF8, 4'b0000, "R4 -2*-4+-8");
      op(2'b00, 1'b1, 32'h0001_0000, 32'h0001_0000, 32'd0, 4'b0011, "R5 zero result sets Z");
      op(2'b01, 1'b1, 32'hFFFF_FFFF, 32'd2, 32'd0, 4'b0110, "R5 negative sets N");
      op(2'b01, 1'b1, 32'd2, 32'd2, 32'd1, 4'b1101, "R5 positive clears N Z");
      op(2'b00, 1'b0, 32'd0, 32'd0, 32'd0, 4'b1111, "R6 no set_flags");
      idle(4'b1010, "R6 idle follows flags_in");
      issue(1'b1, 1'b0, 2'b00, 1'b1, 32'd3, 32'd3, 32'd0, 4'd1, 4'd2, 4'd3, 4'd4,
            4'b0101, "R7 condition fails");
      issue(1'b1, 1'b0, 2'b11, 1'b0, 32'd3, 32'd3, 32'd0, 4'd15, 4'd2, 4'd3, 4'd4,
            4'b0000, "R7 condition fails on bad request");
      op(2'b10, 1'b1, 32'd2, 32'd2, 32'd4, 4'b1001, "R8 mls with set_flags");
      issue(1'b1, 1'b1, 2'b00, 1'b0, 32'd2, 32'd2, 32'd0, 4'd15, 4'd1, 4'd2, 4'd3,
            4'b0000, "R9 reserved destination");
      issue(1'b1, 1'b1, 2'b01, 1'b1, 32'd2, 32'd2, 32'd0, 4'd1, 4'd15, 4'd2, 4'd3,
            4'b0100, "R9 reserved source a");
      issue(1'b1, 1'b1, 2'b01, 1'b0, 32'd2, 32'd2, 32'd0, 4'd1, 4'd2, 4'd15, 4'd3,
            4'b0000, "R9 reserved source b");
      issue(1'b1, 1'b1, 2'b10, 1'b0, 32'd2, 32'd2, 32'd9, 4'd1, 4'd2, 4'd3, 4'd15,
            4'b0000, "R9 reserved source c");
      op(2'b11, 1'b0, 32'd2, 32'd2, 32'd0, 4'b0000, "R10 reserved op");
      op(2'b00, 1'b0, 32'd11, 32'd11, 32'd0, 4'b0000, "R11 back-to-back first");
      op(2'b10, 1'b0, 32'd11, 32'd1, 32'd100, 4'b0000, "R11 back-to-back second");
      idle(4'b0000, "R12 hold after idle");
      idle(4'b0000, "R11 no strobe when idle");

      for (int k = 0; k < 40; k++) begin
         logic [W-1:0] ra, rb, rc;
         lcg = lcg * 32'd1664525 + 32'd1013904223; ra = lcg;
         lcg = lcg * 32'd1664525 + 32'd1013904223; rb = lcg;
         lcg = lcg * 32'd1664525 + 32'd1013904223; rc = lcg;
         op(2'(k % 3), (k % 3) != 2 ? lcg[3] : 1'b0, ra, rb, rc, lcg[7:4],
            (k % 3) == 0 ? "R1 sweep" : ((k % 3) == 1 ? "R2 sweep" : "R3 sweep"));
      end

      idle(4'b0000, "R6 final idle");
      repeat (4) @(posedge clk);
      #1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule